// File: doc/BRIEF.md
# Round-Robin Arbitrated Multiplexer

This block merges the words of several producers into a single output stream. A typical use is sharing one FIFO write port among several producers. Each producer raises a pending flag when it has a word to deliver. The block picks one pending producer per cycle in rotating order and raises that producer's request line for one cycle. In the following cycle the producer may present its word with its valid line. The block registers the word together with the producer's index and an output-valid flag.

Requests can go out on back-to-back cycles, so with every producer pending the output can carry one word per cycle. The consumer on the output side has no way to stall the block and must take every valid word. The number of producers and the word width are parameters. Producer words arrive packed side by side in one vector, with producer `i` in bits `[i*DATA_W +: DATA_W]`.

Top module: `rr_arb_mux`

## Requirements
- R1: A synchronous active-high reset clears every request line and the output-valid flag. It also sets the rotation pointer so that producer 0 has first priority in the first cycle after reset.
- R2: At most one request line is high in any cycle.
- R3: A request goes to the first pending producer found by searching upward from the rotation pointer and wrapping. After a producer is granted, the pointer moves to the index just above it (from N_SRC-1 back to 0).
- R4: When no pending flag is high at a clock edge, every request line is low in the following cycle.
- R5: The request line is registered: a pending flag sampled at one clock edge drives the request line during the cycle after that edge.
- R6: A valid line from a producer whose request line was low in the previous cycle is ignored and produces no output word.
- R7: A word accepted at a clock edge (valid high, request high one cycle earlier) appears on `out_data` after that edge. `out_idx` holds the producer's binary index and `out_vld` is high.
- R8: `out_vld` is low in every cycle after an edge at which no producer delivered an accepted word. This includes a granted producer that leaves its valid line low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_pend | input | N_SRC | Per-producer flag: a word is waiting |
| src_data | input | N_SRC*DATA_W | Packed producer words, producer i at [i*DATA_W +: DATA_W] |
| src_vld | input | N_SRC | Per-producer valid, allowed only the cycle after its request |
| src_req | output | N_SRC | Per-producer request, one-hot or zero |
| out_data | output | DATA_W | Selected word |
| out_idx | output | clog2(N_SRC) | Index of the producer the word came from |
| out_vld | output | 1 | Qualifies out_data and out_idx |

## Verification
A corrupted rotation pointer shows up one cycle later as a request on the wrong line. The bench predicts the request vector every cycle, so a wrong pointer is reported on the first grant it affects. A wrong delayed copy of the request vector shows up two cycles after the grant: either a missing word, or a word taken from a producer that was never asked, with the wrong index. Unsolicited valid pulses and granted producers that stay silent check that the output flag cannot be raised without a proper request-then-valid pair.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;

    // Width of an index field able to address n sources (at least 1 bit).
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Rotate an index by an offset inside [0, n).
    function automatic int wrap_add(input int base, input int offs, input int n);
        int s;
        s = base + offs;
        if (s >= n) s = s - n;
        return s;
    endfunction

endpackage

// File: rtl/rr_grant_gen.sv
module rr_grant_gen
    import rr_arb_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int IW    = idx_bits(N_SRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] pend,
    output logic [N_SRC-1:0] req_q
);

    logic [IW-1:0]    ptr_q;
    logic [N_SRC-1:0] pick;
    logic [IW-1:0]    pick_idx;
    logic             found;

    // Search upward from the pointer, wrapping, first pending wins.
    always_comb begin
        pick     = '0;
        pick_idx = ptr_q;
        found    = 1'b0;
        for (int k = 0; k < N_SRC; k++) begin
            int j;
            j = wrap_add(int'(ptr_q), k, N_SRC);
            if (!found && pend[j]) begin
                pick[j]  = 1'b1;
                pick_idx = IW'(j);
                found    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            ptr_q <= '0;
        end else begin
            req_q <= pick;
            if (found) begin
                ptr_q <= (int'(pick_idx) == N_SRC - 1) ? '0 : pick_idx + 1'b1;
            end
        end
    end

    // R2
    req_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_q));

    // R4
    idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |=> (req_q == '0));

    // R3
    req_was_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q & ~$past(pend)) == '0);

endmodule

// File: rtl/rr_capture.sv
module rr_capture
    import rr_arb_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int DATA_W = 16,
    parameter int IW     = idx_bits(N_SRC)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_SRC-1:0]        req,
    input  logic [N_SRC-1:0]        vld,
    input  logic [N_SRC*DATA_W-1:0] data,
    output logic [DATA_W-1:0]       out_data,
    output logic [IW-1:0]           out_idx,
    output logic                    out_vld
);

    logic [N_SRC-1:0]  req_d;
    logic [N_SRC-1:0]  hit;
    logic [DATA_W-1:0] sel_data;
    logic [IW-1:0]     sel_idx;

    assign hit = vld & req_d;

    always_comb begin
        sel_data = '0;
        sel_idx  = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (hit[i]) begin
                sel_data = sel_data | data[i*DATA_W +: DATA_W];
                sel_idx  = sel_idx | IW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_d    <= '0;
            out_vld  <= 1'b0;
            out_data <= '0;
            out_idx  <= '0;
        end else begin
            req_d    <= req;
            out_vld  <= |hit;
            out_data <= sel_data;
            out_idx  <= sel_idx;
        end
    end

    // R6
    src_had_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> ((($past(vld) >> out_idx) & N_SRC'(1)) != '0));

    // R7
    idx_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (int'(out_idx) < N_SRC));

endmodule

// File: rtl/rr_arb_mux.sv
module rr_arb_mux
    import rr_arb_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int DATA_W = 16,
    localparam int IW    = idx_bits(N_SRC)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_SRC-1:0]        src_pend,
    input  logic [N_SRC*DATA_W-1:0] src_data,
    input  logic [N_SRC-1:0]        src_vld,
    output logic [N_SRC-1:0]        src_req,
    output logic [DATA_W-1:0]       out_data,
    output logic [IW-1:0]           out_idx,
    output logic                    out_vld
);

    rr_grant_gen #(.N_SRC(N_SRC), .IW(IW)) u_grant (
        .clk   (clk),
        .rst   (rst),
        .pend  (src_pend),
        .req_q (src_req)
    );

    rr_capture #(.N_SRC(N_SRC), .DATA_W(DATA_W), .IW(IW)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .req      (src_req),
        .vld      (src_vld),
        .data     (src_data),
        .out_data (out_data),
        .out_idx  (out_idx),
        .out_vld  (out_vld)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (src_req == '0 && !out_vld));

endmodule

// File: tb/tb_rr_arb_mux.sv
module tb_rr_arb_mux;
    localparam int N  = 4;
    localparam int W  = 8;
    localparam int IW = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst;
    logic [N-1:0]   pend, vld, req;
    logic [N*W-1:0] data;
    logic [W-1:0]   odata;
    logic [IW-1:0]  oidx;
    logic           ovld;

    rr_arb_mux #(.N_SRC(N), .DATA_W(W)) dut (
        .clk(clk), .rst(rst), .src_pend(pend), .src_data(data), .src_vld(vld),
        .src_req(req), .out_data(odata), .out_idx(oidx), .out_vld(ovld)
    );

    int checks = 0;
    int fails  = 0;

    // bench model
    logic [N-1:0]  m_req, prev_seen;
    int            m_ptr;
    logic          m_ovld;
    logic [W-1:0]  m_odata;
    logic [IW-1:0] m_oidx;
    logic [3:0]    stamp;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_req = '0; m_ptr = 0; m_ovld = 1'b0; m_odata = '0; m_oidx = '0;
        prev_seen = '0;
    endtask

    // One clock period, entered and left at a falling edge.
    task automatic cycle(input logic [N-1:0] p, input logic [N-1:0] respond,
                         input logic [N-1:0] rogue, input string otag);
        logic [N-1:0] v, acc, nreq;
        string rt, ot;
        rt = (m_req == '0) ? "R4" : "R3";
        chk(rt, 64'(req), 64'(m_req));
        chk("R2", 64'($countones(req) <= 1), 64'(1));
        ot = (otag != "") ? otag : (m_ovld ? "R7" : "R8");
        chk(ot, 64'(ovld), 64'(m_ovld));
        if (m_ovld) begin
            chk("R7", 64'(odata), 64'(m_odata));
            chk("R7", 64'(oidx), 64'(m_oidx));
        end
        for (int i = 0; i < N; i++) data[i*W +: W] = {stamp, 4'(i)};
        v   = (respond & prev_seen) | rogue;
        acc = v & prev_seen;
        m_ovld = |acc;
        for (int i = 0; i < N; i++) if (acc[i]) begin
            m_odata = {stamp, 4'(i)};
            m_oidx  = IW'(i);
        end
        nreq = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (m_ptr + k) % N;
            if (nreq == '0 && p[j]) begin
                nreq[j] = 1'b1;
                m_ptr = (j + 1) % N;
            end
        end
        m_req = nreq;
        prev_seen = req;
        stamp = stamp + 4'd1;
        pend = p;
        vld  = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; pend = '0; vld = '0;
        @(negedge clk); @(negedge clk);
        chk("R1", 64'(req), 64'(0));
        chk("R1", 64'(ovld), 64'(0));
        rst = 1'b0;
        model_reset();
    endtask

    task automatic t_single();
        cycle(4'b0100, 4'b1111, '0, "");
        chk("R5", 64'(req), 64'(4'b0100));
        cycle(4'b0000, 4'b1111, '0, "");
        cycle(4'b0000, 4'b1111, '0, "");
        cycle(4'b0000, 4'b1111, '0, "");
    endtask

    task automatic t_idle();
        for (int c = 0; c < 4; c++) cycle(4'b0000, 4'b1111, '0, "R8");
    endtask

    task automatic t_stream();
        for (int c = 0; c < 10; c++) cycle(4'b1111, 4'b1111, '0, "");
        for (int c = 0; c < 3; c++) cycle(4'b0000, 4'b1111, '0, "");
    endtask

    task automatic t_sparse();
        for (int c = 0; c < 8; c++) cycle((c % 2 == 0) ? 4'b1010 : 4'b0011, 4'b1111, '0, "");
        for (int c = 0; c < 3; c++) cycle(4'b0000, 4'b1111, '0, "");
    endtask

    task automatic t_rogue();
        for (int c = 0; c < 3; c++) cycle(4'b0000, '0, 4'b1111, "R6");
        cycle(4'b0001, 4'b1111, 4'b0000, "");
        cycle(4'b0000, 4'b1111, 4'b1110, "R6");
        cycle(4'b0000, 4'b1111, 4'b1110, "R6");
        cycle(4'b0000, 4'b1111, 4'b1110, "R6");
    endtask

    task automatic t_declined();
        for (int c = 0; c < 5; c++) cycle(4'b1111, 4'b0000, '0, "R8");
        for (int c = 0; c < 3; c++) cycle(4'b0000, 4'b0000, '0, "R8");
    endtask

    task automatic t_reset_mid();
        for (int c = 0; c < 3; c++) cycle(4'b1111, 4'b1111, '0, "");
        t_reset();
        cycle(4'b1111, 4'b1111, '0, "R1");
        chk("R1", 64'(req), 64'(4'b0001));
        for (int c = 0; c < 4; c++) cycle(4'b0000, 4'b1111, '0, "");
    endtask

    initial begin
        #(20 * 100000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        stamp = 4'd1; data = '0;
        model_reset();
        @(negedge clk);
        t_reset();
        t_single();
        t_idle();
        t_stream();
        t_sparse();
        t_rogue();
        t_declined();
        t_reset_mid();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule